// File: doc/BRIEF.md
# Reset Cause Collector and Release Sequencer

This block gathers every reason the chip may need a reset, records which reasons occurred in a status byte that the bus can read, and controls the reset itself. An internal cause makes the block enable the pull-down of the open-drain reset pin and hold the core (CPU and memories) in reset. The block can also start the clock state machine. There are four internal causes: a watchdog overflow request, a decoded illegal instruction, an opcode fetch from an unmapped address, and a low-voltage flag. The power-on signal is the fifth cause. It is the block's asynchronous active-low reset.

An instruction-decode strobe or a watchdog request starts a reset. The low-voltage flag holds the reset for as long as it is high. When the last cause goes away, the pin stays driven for a fixed count of fast-clock cycles. The core reset is then held for a shorter tail count before it is released. A STOP instruction counts as an illegal instruction when the stop-enable option bit is clear. The unmapped address windows are given as parameter lists of inclusive low/high bounds. Only opcode fetches are compared against them.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While power-on (por_ni low) is asserted, and directly after it ends, the status byte reads 0x01 (bit 0 = power-on, all other bits 0), pin_pd_o is 1 and core_rst_o is 1.
- R2: A watchdog request (wdog_req_i high for a cycle) sets status bit 1 and drives pin_pd_o and core_rst_o high from the next cycle.
- R3: An illegal-instruction strobe (bad_op_i) sets status bit 2 and starts a reset.
- R4: A STOP strobe (stop_op_i) with stop_ena_i = 0 sets status bit 2 and starts a reset. With stop_ena_i = 1 the STOP strobe changes neither the status nor the pin.
- R5: A fetch (fetch_i) with fetch_op_i = 1 whose address lies in an unmapped window sets status bit 3 and starts a reset. The default windows are 0x0100–0x7FFF and 0xF000–0xF7FF, both inclusive. A fetch with fetch_op_i = 0, or an opcode fetch outside the windows, has no effect.
- R6: low_volt_i high sets status bit 4 and keeps pin_pd_o at 1 for every cycle in which it is high.
- R7: The clock edge that samples the last active cause is counted as edge 0. pin_pd_o stays 1 through edge 4095 and drops at edge 4096.
- R8: core_rst_o stays 1 for 64 further cycles after pin_pd_o drops, then goes to 0.
- R9: A one-cycle stat_rd_i clears the status byte at the next edge. A cause that occurs in the same cycle still sets its bit.
- R10: A new cause during the pin or tail phase restarts the 4096-cycle count.
- R11: clk_en_o is 0 during power-on and 1 from the first clock edge after power-on ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous |
| wdog_req_i | input | 1 | Watchdog overflow request |
| bad_op_i | input | 1 | Decoded illegal-instruction strobe |
| stop_op_i | input | 1 | STOP instruction strobe |
| stop_ena_i | input | 1 | Option bit: 1 permits STOP |
| fetch_i | input | 1 | Bus fetch strobe |
| fetch_op_i | input | 1 | 1 = opcode fetch, 0 = data fetch |
| fetch_addr_i | input | 16 | Fetch address |
| low_volt_i | input | 1 | Low-voltage flag |
| stat_rd_i | input | 1 | Status read strobe (read clears) |
| pin_pd_o | output | 1 | Reset pin pull-down enable |
| core_rst_o | output | 1 | Internal CPU/memory reset |
| clk_en_o | output | 1 | Clock state machine enable |
| stat_o | output | 8 | Reset cause status byte |

## Verification
The hardest situation to reach is a new cause that arrives part-way through an earlier release sequence. The bench issues a watchdog request, waits 2000 cycles, and then sends an illegal-instruction strobe. It then confirms at the exact edge that the pin release is counted from the second cause and not the first. A second hard case is a read strobe and a new cause in the same cycle; the stimulus drives both in one cycle. The per-cycle reference model also catches any off-by-one in the pin and tail phases at the window boundaries 0x00FF, 0xF7FF and 0xF800.

// File: rtl/rst_pkg.sv
package rst_pkg;
  localparam int STAT_W   = 8;
  localparam int B_POR    = 0;
  localparam int B_WDOG   = 1;
  localparam int B_BADOP  = 2;
  localparam int B_BADADR = 3;
  localparam int B_LOWV   = 4;

  typedef enum logic [1:0] {
    SQ_RUN  = 2'd0,
    SQ_PIN  = 2'd1,
    SQ_TAIL = 2'd2
  } seq_t;
endpackage

// File: rtl/rst_addr_chk.sv
module rst_addr_chk #(
  parameter int ADDR_W   = 16,
  parameter int N_RANGES = 2,
  parameter logic [N_RANGES*ADDR_W-1:0] RANGE_LO = {16'hF000, 16'h0100},
  parameter logic [N_RANGES*ADDR_W-1:0] RANGE_HI = {16'hF7FF, 16'h7FFF}
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic [N_RANGES-1:0] hit_v;

  for (genvar g = 0; g < N_RANGES; g++) begin : g_win
    localparam logic [ADDR_W-1:0] LO = RANGE_LO[g*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] HI = RANGE_HI[g*ADDR_W +: ADDR_W];
    assign hit_v[g] = (addr_i >= LO) && (addr_i <= HI);
  end

  assign hit_o = |hit_v;
endmodule

// File: rtl/rst_status.sv
module rst_status
  import rst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wdog_i,
  input  logic              badop_i,
  input  logic              badadr_i,
  input  logic              lowv_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] stat_q, stat_d, set_v;

  always_comb begin
    set_v           = '0;
    set_v[B_WDOG]   = wdog_i;
    set_v[B_BADOP]  = badop_i;
    set_v[B_BADADR] = badadr_i;
    set_v[B_LOWV]   = lowv_i;
    stat_d          = (rd_i ? '0 : stat_q) | set_v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q        <= '0;
      stat_q[B_POR] <= 1'b1;
    end else begin
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;

  // R9
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wdog_i && !badop_i && !badadr_i && !lowv_i) |=> (stat_o == '0));

  // R2
  wdog_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_i |=> stat_o[B_WDOG]);
endmodule

// File: rtl/rst_seq.sv
module rst_seq
  import rst_pkg::*;
#(
  parameter int HOLD_CYC = 4096,
  parameter int TAIL_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cause_i,
  input  logic level_i,
  output logic pin_pd_o,
  output logic core_rst_o,
  output logic clk_en_o
);
  localparam int MAXC  = (HOLD_CYC > TAIL_CYC) ? HOLD_CYC : TAIL_CYC;
  localparam int CNT_W = $clog2(MAXC) + 1;
  localparam logic [CNT_W-1:0] HOLD_END = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] TAIL_END = CNT_W'(TAIL_CYC - 1);

  seq_t             st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cen_q, cen_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    cen_d = 1'b1;
    if (cause_i || level_i) begin
      st_d  = SQ_PIN;
      cnt_d = '0;
    end else begin
      case (st_q)
        SQ_PIN: begin
          if (cnt_q == HOLD_END) begin
            st_d  = SQ_TAIL;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        SQ_TAIL: begin
          if (cnt_q == TAIL_END) begin
            st_d  = SQ_RUN;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          st_d  = SQ_RUN;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SQ_PIN;
      cnt_q <= '0;
      cen_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      cen_q <= cen_d;
    end
  end

  assign pin_pd_o   = (st_q == SQ_PIN);
  assign core_rst_o = (st_q != SQ_RUN);
  assign clk_en_o   = cen_q;

  // R8
  pin_in_core_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_pd_o |-> core_rst_o);

  // R8
  tail_after_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pin_pd_o) |-> core_rst_o);

  // R10
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_i || level_i) |=> (pin_pd_o && cnt_q == '0));
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rst_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int N_RANGES = 2,
  parameter logic [N_RANGES*ADDR_W-1:0] RANGE_LO = {16'hF000, 16'h0100},
  parameter logic [N_RANGES*ADDR_W-1:0] RANGE_HI = {16'hF7FF, 16'h7FFF},
  parameter int HOLD_CYC = 4096,
  parameter int TAIL_CYC = 64
) (
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              wdog_req_i,
  input  logic              bad_op_i,
  input  logic              stop_op_i,
  input  logic              stop_ena_i,
  input  logic              fetch_i,
  input  logic              fetch_op_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              low_volt_i,
  input  logic              stat_rd_i,
  output logic              pin_pd_o,
  output logic              core_rst_o,
  output logic              clk_en_o,
  output logic [STAT_W-1:0] stat_o
);
  logic win_hit, badop_ev, badadr_ev, strobe_ev;

  rst_addr_chk #(
    .ADDR_W(ADDR_W), .N_RANGES(N_RANGES),
    .RANGE_LO(RANGE_LO), .RANGE_HI(RANGE_HI)
  ) u_win (
    .addr_i(fetch_addr_i),
    .hit_o (win_hit)
  );

  assign badop_ev  = bad_op_i || (stop_op_i && !stop_ena_i);
  assign badadr_ev = fetch_i && fetch_op_i && win_hit;
  assign strobe_ev = wdog_req_i || badop_ev || badadr_ev;

  rst_status u_stat (
    .clk_i   (clk_i),
    .rst_ni  (por_ni),
    .rd_i    (stat_rd_i),
    .wdog_i  (wdog_req_i),
    .badop_i (badop_ev),
    .badadr_i(badadr_ev),
    .lowv_i  (low_volt_i),
    .stat_o  (stat_o)
  );

  rst_seq #(.HOLD_CYC(HOLD_CYC), .TAIL_CYC(TAIL_CYC)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (por_ni),
    .cause_i   (strobe_ev),
    .level_i   (low_volt_i),
    .pin_pd_o  (pin_pd_o),
    .core_rst_o(core_rst_o),
    .clk_en_o  (clk_en_o)
  );

  // R6
  lowv_pin_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    low_volt_i |=> (pin_pd_o && stat_o[B_LOWV]));

  // R5
  data_fetch_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    (!(fetch_i && fetch_op_i) && !stat_rd_i) |=> $stable(stat_o[B_BADADR]));

  // R4
  stop_ok_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    (stop_ena_i && !bad_op_i && !stat_rd_i) |=> $stable(stat_o[B_BADOP]));
endmodule

// File: tb/tb_rst_cause_ctrl.sv
module tb_rst_cause_ctrl;
  localparam int HOLD = 4096;
  localparam int TAIL = 64;

  logic        clk = 1'b0;
  logic        por_n, wdog, bop, stp, stp_en, fch, fop, lvi, rd;
  logic [15:0] addr;
  logic        pin, crst, cen;
  logic [7:0]  stat;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  // reference model state
  int       m_pin, m_tail;
  bit [7:0] m_stat;
  bit       m_cen;

  always #5 clk = ~clk;

  rst_cause_ctrl dut (
    .clk_i(clk), .por_ni(por_n), .wdog_req_i(wdog), .bad_op_i(bop),
    .stop_op_i(stp), .stop_ena_i(stp_en), .fetch_i(fch), .fetch_op_i(fop),
    .fetch_addr_i(addr), .low_volt_i(lvi), .stat_rd_i(rd),
    .pin_pd_o(pin), .core_rst_o(crst), .clk_en_o(cen), .stat_o(stat)
  );

  function automatic bit unmapped(input logic [15:0] a);
    return (a >= 16'h0100 && a <= 16'h7FFF) || (a >= 16'hF000 && a <= 16'hF7FF);
  endfunction

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_pin = HOLD; m_tail = TAIL; m_stat = 8'h01; m_cen = 1'b0;
    end else begin
      bit w, o, a;
      w = wdog;
      o = bop || (stp && !stp_en);
      a = fch && fop && unmapped(addr);
      m_cen = 1'b1;
      if (rd) m_stat = 8'h00;
      if (w) m_stat[1] = 1'b1;
      if (o) m_stat[2] = 1'b1;
      if (a) m_stat[3] = 1'b1;
      if (lvi) m_stat[4] = 1'b1;
      if (w || o || a || lvi) begin
        m_pin = HOLD; m_tail = TAIL;
      end else if (m_pin > 0) m_pin = m_pin - 1;
      else if (m_tail > 0) m_tail = m_tail - 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (por_n && !done) begin
      chk("R7 pin", {31'd0, pin}, {31'd0, (m_pin > 0)});
      chk("R8 core", {31'd0, crst}, {31'd0, (m_pin > 0 || m_tail > 0)});
      chk("R9 status", {24'd0, stat}, {24'd0, m_stat});
      chk("R11 clken", {31'd0, cen}, {31'd0, m_cen});
    end
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int which, input logic [15:0] a, input logic op);
    @(negedge clk);
    case (which)
      0: wdog = 1'b1;
      1: bop  = 1'b1;
      2: stp  = 1'b1;
      3: begin fch = 1'b1; fop = op; addr = a; end
      default: rd = 1'b1;
    endcase
    @(negedge clk);
    wdog = 0; bop = 0; stp = 0; fch = 0; fop = 0; rd = 0; addr = 16'h0;
  endtask

  task automatic finish_seq();
    step(HOLD + TAIL + 4);
    pulse(4, 16'h0, 1'b0);
  endtask

  initial begin
    por_n = 1'b1; wdog = 0; bop = 0; stp = 0; stp_en = 1'b1;
    fch = 0; fop = 0; lvi = 0; rd = 0; addr = 16'h0;
    #1 por_n = 1'b0;
    step(3);
    chk("R11 clken in por", {31'd0, cen}, 32'd0);
    chk("R1 stat in por", {24'd0, stat}, 32'h01);
    por_n = 1'b1;
    #1;
    chk("R1 stat", {24'd0, stat}, 32'h01);
    chk("R1 pin", {31'd0, pin}, 32'd1);
    chk("R1 core", {31'd0, crst}, 32'd1);
    step(1);
    chk("R11 clken", {31'd0, cen}, 32'd1);
    finish_seq();
    chk("R8 released", {31'd0, crst}, 32'd0);
    chk("R9 cleared", {24'd0, stat}, 32'h00);

    // watchdog with exact release edges
    pulse(0, 16'h0, 1'b0);
    chk("R2 stat", {24'd0, stat}, 32'h02);
    chk("R2 pin", {31'd0, pin}, 32'd1);
    step(HOLD - 1);
    chk("R7 pin held", {31'd0, pin}, 32'd1);
    step(1);
    chk("R7 pin drop", {31'd0, pin}, 32'd0);
    chk("R8 core tail", {31'd0, crst}, 32'd1);
    step(TAIL - 1);
    chk("R8 core held", {31'd0, crst}, 32'd1);
    step(1);
    chk("R8 core drop", {31'd0, crst}, 32'd0);
    pulse(4, 16'h0, 1'b0);

    // illegal opcode
    pulse(1, 16'h0, 1'b0);
    chk("R3 stat", {24'd0, stat}, 32'h04);
    chk("R3 pin", {31'd0, pin}, 32'd1);
    finish_seq();

    // STOP allowed then forbidden
    stp_en = 1'b1;
    pulse(2, 16'h0, 1'b0);
    chk("R4 stop ok stat", {24'd0, stat}, 32'h00);
    chk("R4 stop ok pin", {31'd0, pin}, 32'd0);
    stp_en = 1'b0;
    pulse(2, 16'h0, 1'b0);
    chk("R4 stop bad stat", {24'd0, stat}, 32'h04);
    chk("R4 stop bad pin", {31'd0, pin}, 32'd1);
    stp_en = 1'b1;
    finish_seq();

    // fetch checks
    pulse(3, 16'h0200, 1'b0);
    chk("R5 data fetch", {24'd0, stat}, 32'h00);
    pulse(3, 16'h8000, 1'b1);
    chk("R5 mapped op", {24'd0, stat}, 32'h00);
    pulse(3, 16'h00FF, 1'b1);
    chk("R5 below window", {24'd0, stat}, 32'h00);
    pulse(3, 16'hF800, 1'b1);
    chk("R5 above window", {31'd0, pin}, 32'd0);
    pulse(3, 16'hF7FF, 1'b1);
    chk("R5 unmapped op", {24'd0, stat}, 32'h08);
    chk("R5 pin", {31'd0, pin}, 32'd1);
    finish_seq();

    // low voltage held
    @(negedge clk); lvi = 1'b1;
    step(6000);
    chk("R6 pin held", {31'd0, pin}, 32'd1);
    chk("R6 stat", {24'd0, stat}, 32'h10);
    lvi = 1'b0;
    step(HOLD - 1);
    chk("R6 pin after drop", {31'd0, pin}, 32'd1);
    step(1);
    chk("R7 lvi release", {31'd0, pin}, 32'd0);
    finish_seq();

    // restart mid-sequence
    pulse(0, 16'h0, 1'b0);
    step(2000);
    pulse(1, 16'h0, 1'b0);
    step(HOLD - 1);
    chk("R10 restart held", {31'd0, pin}, 32'd1);
    step(1);
    chk("R10 restart drop", {31'd0, pin}, 32'd0);
    step(TAIL + 4);

    // read and set in the same cycle
    @(negedge clk); rd = 1'b1; wdog = 1'b1;
    @(negedge clk); rd = 1'b0; wdog = 1'b0;
    chk("R9 read with set", {24'd0, stat}, 32'h02);
    finish_seq();
    chk("R9 final clear", {24'd0, stat}, 32'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule